// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer Bank

This block holds six independent up-counting timers behind a simple word-addressed register port. Each channel has an enable, a self-clearing counter-reset request, a two-bit operating mode, a clock-source choice between two tick-enable inputs (a fast system tick and a slow real-time tick), a divide-by-one-or-two prescaler, a compare value and a counter that can be read at any moment as a timestamp. A channel can fire once and stop, fire periodically with automatic reload, or run freely as a wrapping timebase.

Compare events set per-channel pending flags in a shared interrupt block. Software clears a flag by writing a one to its bit, and a separate enable mask decides which pending flags reach the single interrupt output. Channels are numbered 1 to 6, so channel n occupies the 16-byte window at 0x10·n and the two global registers share window 0. The usual sequence for software is to program the compare value, then write the control register with the enable and clear bits both set, so that counting starts from zero.

Top module: `gpt_bank`

## Requirements
- R1: After reset every register reads 0: all channels are disabled, in one-shot mode, with compare 0, count 0, fast source and no division. The interrupt output is low.
- R2: The global interrupt-enable register is at 0x00 and the pending/acknowledge register is at 0x08. Bit n-1 of each belongs to channel n, and bits above 5 read 0. Channel n (1..6) decodes control at 0x10·n, clock configuration at +0x04, count at +0x08 and compare at +0x0C. Any other word address, and any address with bits [1:0] not 0, reads 0.
- R3: In the control register, bit 0 is the enable and bits [5:4] are the mode (0 one-shot, 1 repeat, 3 free-running, 2 acts as one-shot). Writing bit 1 as 1 forces the count to 0. Bit 1 always reads 0, and the mode and enable read back.
- R4: While its channel is enabled, the count rises by one on each selected, prescaled tick. Writes to the count address are ignored.
- R5: In the clock configuration register, bit 4 selects the tick (0 fast, 1 slow) and bit 0 selects the prescaler (0 counts every tick, 1 counts every second tick). Ticks on the unselected input have no effect.
- R6: In one-shot mode (mode 0 or 2), the tick that brings the count to the compare value sets the channel's pending flag. The count then holds at the compare value and the enable bit drops to 0.
- R7: In repeat mode, the tick that would bring the count to the compare value sets the pending flag and loads the count with 0 on that same edge. Counting continues, so one period is compare ticks long.
- R8: In free-running mode no pending flag is ever set, and the count wraps from its all-ones value to 0.
- R9: Clearing the enable bit freezes the count at its current value.
- R10: Writing 1 to a bit of the acknowledge register clears that pending flag, and writing 0 leaves it unchanged. Reading that address returns the raw pending flags.
- R11: The interrupt output is high exactly when some pending flag has its enable bit set. A pending flag still sets while its enable bit is 0.
- R12: When a compare event and a write-one acknowledge of the same channel land in the same cycle, the flag stays set.
- R13: A control-register write to a channel takes the place of that channel's count step in the same cycle: the tick in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fast_tick | input | 1 | Fast system tick enable, one clock wide per tick |
| slow_tick | input | 1 | Slow real-time tick enable, one clock wide per tick |
| irq | output | 1 | OR of the pending flags that are enabled |

## Verification
On every cycle, the assertions check the following cycle-level relations: a clear request zeroes the count, a repeat match reloads 0, a one-shot match drops the enable, a free-running channel never signals a match, a disabled channel's count stays still, and a match always leaves its pending flag set even under a simultaneous acknowledge. Only the bench's scenarios can show the following. Prescaler and source selection give the right tick counts. The address map decodes and reads back correctly. Repeat periods have the right length. A control write swallows a tick. The interrupt output follows the enable mask. A narrow instance wraps its counter.

// File: rtl/gpt_pkg.sv
// Package: shared types and field positions for the timer bank.
// Assumes word-aligned 32-bit registers, four per channel window.
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_ALT    = 2'd2,
        MODE_FREE   = 2'd3
    } tmr_mode_e;

    // Register slot within a channel window (address bits [3:2]).
    localparam logic [1:0] SLOT_CTRL  = 2'd0;
    localparam logic [1:0] SLOT_CLK   = 2'd1;
    localparam logic [1:0] SLOT_COUNT = 2'd2;
    localparam logic [1:0] SLOT_CMP   = 2'd3;

    // Control and clock configuration field positions.
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CLK_DIV_BIT   = 0;
    localparam int CLK_SRC_BIT   = 4;

endpackage

// File: rtl/gpt_tick_div.sv
// Module: picks one of two tick enables and optionally halves its rate.
// Assumes ticks are one-clock pulses. The phase restarts on a clear request
// so that a freshly started channel counts on the second tick when halving.
module gpt_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,        // channel enabled and not being written
    input  logic restart,    // clear request resets the phase
    input  logic src_slow,
    input  logic div_two,
    input  logic fast_tick,
    input  logic slow_tick,
    output logic step
);
    logic sel_tick;
    logic phase_q;

    // Selected tick that the channel is allowed to use this cycle.
    always_comb sel_tick = run && (src_slow ? slow_tick : fast_tick);

    // Phase toggle for the divide-by-two setting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= 1'b0;
        end else if (sel_tick && div_two) begin
            phase_q <= ~phase_q;
        end
    end

    // Count step: every tick, or every second tick when halving.
    always_comb step = sel_tick && (!div_two || phase_q);

endmodule

// File: rtl/gpt_channel.sv
// Module: one timer channel with control, clock configuration, count and
// compare registers. Assumes at most one register write per cycle; a control
// write takes precedence over a count step in the same cycle.
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             clk_wr,
    input  logic             cmp_wr,
    input  logic [31:0]      wdata,
    input  logic             fast_tick,
    input  logic             slow_tick,
    output logic             en_o,
    output tmr_mode_e        mode_o,
    output logic             src_o,
    output logic             div_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             match_o
);
    logic             en_q;
    tmr_mode_e        mode_q;
    logic             src_q;
    logic             div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_next;
    logic             step;
    logic             hit;
    logic             clr_req;

    // Clear request decoded from a control write.
    always_comb clr_req = ctrl_wr && wdata[CTRL_CLR_BIT];

    gpt_tick_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en_q && !ctrl_wr),
        .restart   (clr_req),
        .src_slow  (src_q),
        .div_two   (div_q),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .step      (step)
    );

    // Compare detection on the value the count is about to take.
    always_comb begin
        cnt_next = cnt_q + 1'b1;
        hit      = step && (mode_q != MODE_FREE) && (cnt_next == cmp_q);
    end

    // Control, enable and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_ONCE;
            cnt_q  <= '0;
        end else if (ctrl_wr) begin
            en_q   <= wdata[CTRL_EN_BIT];
            mode_q <= tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
            if (wdata[CTRL_CLR_BIT]) begin
                cnt_q <= '0;
            end
        end else if (hit) begin
            if (mode_q == MODE_REPEAT) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_next;
                en_q  <= 1'b0;
            end
        end else if (step) begin
            cnt_q <= cnt_next;
        end
    end

    // Clock source, prescaler and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            div_q <= 1'b0;
            cmp_q <= '0;
        end else begin
            if (clk_wr) begin
                src_q <= wdata[CLK_SRC_BIT];
                div_q <= wdata[CLK_DIV_BIT];
            end
            if (cmp_wr) begin
                cmp_q <= wdata[CNT_W-1:0];
            end
        end
    end

    assign en_o    = en_q;
    assign mode_o  = mode_q;
    assign src_o   = src_q;
    assign div_o   = div_q;
    assign count_o = cnt_q;
    assign cmp_o   = cmp_q;
    assign match_o = hit;

    // R3: a clear request leaves the count at zero.
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt_q == '0));

    // R6: a one-shot match drops the enable.
    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q != MODE_REPEAT) |=> !en_q);

    // R7: a repeat match reloads zero on the same edge.
    assert_repeat_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MODE_REPEAT) |=> (cnt_q == '0));

    // R8: free-running channels never report a match.
    assert_free_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FREE) |-> !match_o);

    // R9: a disabled channel holds its count unless written.
    assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/gpt_irq.sv
// Module: shared interrupt enable mask and pending flags with write-one
// acknowledge. Assumes match pulses are one cycle wide; a match beats an
// acknowledge of the same bit in the same cycle.
module gpt_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_wr,
    input  logic           ack_wr,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] match,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] pend_o,
    output logic           irq_o
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] ack_mask;

    // Bits the current write acknowledges.
    always_comb ack_mask = ack_wr ? wbits : '0;

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wbits;
        end
    end

    // Pending flags: set by match, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_mask) | match;
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_q);

    // R12: every match leaves its pending flag set, even under an acknowledge.
    assert_match_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> ((pend_q & $past(match)) == $past(match)));

    // R10: without a match, writing zeros to acknowledge changes nothing.
    assert_ack_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && wbits == '0 && match == '0) |=> $stable(pend_q));

endmodule

// File: rtl/gpt_bank.sv
// Module: top of the timer bank. Decodes the register window, instantiates
// one channel per index 1..NCH and the shared interrupt block, and muxes
// read data combinationally. Assumes byte addresses, word-aligned access.
module gpt_bank
    import gpt_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int CNT_W = 32,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          fast_tick,
    input  logic          slow_tick,
    output logic          irq
);
    localparam int IDX_W = AW - 4;

    logic [IDX_W-1:0] win_idx;
    logic [1:0]       slot;
    logic             aligned;
    logic             glb_sel;
    logic [NCH-1:0]   ch_sel;

    logic [NCH-1:0]   ch_en;
    tmr_mode_e        ch_mode [NCH];
    logic [NCH-1:0]   ch_src;
    logic [NCH-1:0]   ch_div;
    logic [CNT_W-1:0] ch_cnt  [NCH];
    logic [CNT_W-1:0] ch_cmp  [NCH];
    logic [NCH-1:0]   ch_match;
    logic [NCH-1:0]   irq_en;
    logic [NCH-1:0]   irq_pend;

    // Address split into window index and register slot.
    always_comb begin
        win_idx = bus_addr[AW-1:4];
        slot    = bus_addr[3:2];
        aligned = (bus_addr[1:0] == 2'b00);
        glb_sel = aligned && (win_idx == '0);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            // Channel gi+1 owns window gi+1.
            always_comb ch_sel[gi] = aligned && (win_idx == IDX_W'(gi + 1));

            gpt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctrl_wr   (bus_wr && ch_sel[gi] && slot == SLOT_CTRL),
                .clk_wr    (bus_wr && ch_sel[gi] && slot == SLOT_CLK),
                .cmp_wr    (bus_wr && ch_sel[gi] && slot == SLOT_CMP),
                .wdata     (bus_wdata),
                .fast_tick (fast_tick),
                .slow_tick (slow_tick),
                .en_o      (ch_en[gi]),
                .mode_o    (ch_mode[gi]),
                .src_o     (ch_src[gi]),
                .div_o     (ch_div[gi]),
                .count_o   (ch_cnt[gi]),
                .cmp_o     (ch_cmp[gi]),
                .match_o   (ch_match[gi])
            );
        end
    endgenerate

    gpt_irq #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (bus_wr && glb_sel && slot == 2'd0),
        .ack_wr (bus_wr && glb_sel && slot == 2'd2),
        .wbits  (bus_wdata[NCH-1:0]),
        .match  (ch_match),
        .en_o   (irq_en),
        .pend_o (irq_pend),
        .irq_o  (irq)
    );

    // Read data mux over global and channel registers.
    always_comb begin
        bus_rdata = '0;
        if (glb_sel) begin
            if (slot == 2'd0) bus_rdata = 32'(irq_en);
            if (slot == 2'd2) bus_rdata = 32'(irq_pend);
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) begin
                case (slot)
                    SLOT_CTRL: begin
                        bus_rdata[CTRL_EN_BIT]           = ch_en[i];
                        bus_rdata[CTRL_MODE_LSB +: 2]    = ch_mode[i];
                    end
                    SLOT_CLK: begin
                        bus_rdata[CLK_SRC_BIT] = ch_src[i];
                        bus_rdata[CLK_DIV_BIT] = ch_div[i];
                    end
                    SLOT_COUNT: bus_rdata = 32'(ch_cnt[i]);
                    default:    bus_rdata = 32'(ch_cmp[i]);
                endcase
            end
        end
    end

    // R2: at most one window is decoded at a time.
    assert_one_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({glb_sel, ch_sel}));

endmodule

// File: tb/gpt_bank_test.sv
module gpt_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] small_rdata;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        irq;
    logic        small_irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpt_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .irq(irq)
    );

    // Narrow-counter copy on the same bus, used for the wrap check.
    gpt_bank #(.CNT_W(8)) uut_small (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(small_rdata),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .irq(small_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input logic f, input logic s, input int n);
        fast_tick = f; slow_tick = s;
        repeat (n) @(negedge clk);
        fast_tick = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8'h70; a += 4) begin
            rd(8'(a), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(8'h00, 32'hFF);
        rd(8'h00, d); check("R2 enable mask width", d, 32'h3F);
        wr(8'h00, 32'h0);
        rd(8'h04, d); check("R2 unmapped 0x04", d, 32'h0);
        rd(8'h0C, d); check("R2 unmapped 0x0C", d, 32'h0);
        wr(8'h3C, 32'hABCD);
        rd(8'h3C, d); check("R2 ch3 compare", d, 32'hABCD);
        rd(8'h3D, d); check("R2 misaligned reads 0", d, 32'h0);
        rd(8'h70, d); check("R2 window 7 reads 0", d, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] d;
        wr(8'h20, 32'h33);
        rd(8'h20, d); check("R3 ctrl readback clear bit 0", d, 32'h31);
        ticks(1'b1, 1'b0, 5);
        rd(8'h28, d); check("R4 count after 5 ticks", d, 32'd5);
        wr(8'h28, 32'h1234);
        rd(8'h28, d); check("R4 count write ignored", d, 32'd5);
        ticks(1'b0, 1'b1, 3);
        rd(8'h28, d); check("R5 unselected slow tick ignored", d, 32'd5);
        wr(8'h20, 32'h30);
        ticks(1'b1, 1'b0, 4);
        rd(8'h28, d); check("R9 frozen when disabled", d, 32'd5);
        wr(8'h20, 32'h33);
        rd(8'h28, d); check("R3 clear zeroes count", d, 32'd0);
    endtask

    task automatic t_ctrl_swallow;
        logic [31:0] d;
        // ch2 free-running from 0; 7 tick edges, one of them a control write.
        fast_tick = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h20, 32'h31);
        repeat (3) @(negedge clk);
        fast_tick = 1'b0;
        rd(8'h28, d); check("R13 control write swallows a tick", d, 32'd6);
        wr(8'h20, 32'h30);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        wr(8'h34, 32'h11);
        rd(8'h34, d); check("R5 clock config readback", d, 32'h11);
        wr(8'h30, 32'h33);
        ticks(1'b0, 1'b1, 6);
        rd(8'h38, d); check("R5 slow halved", d, 32'd3);
        ticks(1'b1, 1'b0, 4);
        rd(8'h38, d); check("R5 fast ignored on slow source", d, 32'd3);
        wr(8'h30, 32'h30);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(8'h1C, 32'd4);
        wr(8'h00, 32'h01);
        wr(8'h10, 32'h03);
        ticks(1'b1, 1'b0, 3);
        rd(8'h08, d); check("R6 no pending before compare", d & 32'h1, 32'h0);
        ticks(1'b1, 1'b0, 3);
        rd(8'h18, d); check("R6 count holds at compare", d, 32'd4);
        rd(8'h10, d); check("R6 enable dropped", d, 32'h00);
        rd(8'h08, d); check("R6 pending set", d & 32'h1, 32'h1);
        check("R11 irq with enabled pending", 32'(irq), 32'h1);
        wr(8'h08, 32'h0);
        rd(8'h08, d); check("R10 zero ack no effect", d & 32'h1, 32'h1);
        wr(8'h08, 32'h1);
        rd(8'h08, d); check("R10 one ack clears", d & 32'h1, 32'h0);
        check("R11 irq low after ack", 32'(irq), 32'h0);
    endtask

    task automatic t_mode_alt;
        logic [31:0] d;
        wr(8'h4C, 32'd2);
        wr(8'h40, 32'h23);
        ticks(1'b1, 1'b0, 5);
        rd(8'h48, d); check("R3 mode 2 stops like one-shot", d, 32'd2);
        rd(8'h40, d); check("R3 mode 2 readback, disabled", d, 32'h20);
        rd(8'h08, d); check("R11 pending sets while masked", d & 32'h8, 32'h8);
        check("R11 irq low while masked", 32'(irq), 32'h0);
        wr(8'h00, 32'h09);
        check("R11 irq after unmask", 32'(irq), 32'h1);
        wr(8'h08, 32'h08);
        check("R11 irq after ack", 32'(irq), 32'h0);
        wr(8'h00, 32'h00);
    endtask

    task automatic t_repeat;
        logic [31:0] d;
        wr(8'h5C, 32'd3);
        wr(8'h50, 32'h13);
        ticks(1'b1, 1'b0, 2);
        rd(8'h58, d); check("R7 count before compare", d, 32'd2);
        rd(8'h08, d); check("R7 no pending yet", d & 32'h10, 32'h0);
        ticks(1'b1, 1'b0, 1);
        rd(8'h58, d); check("R7 reload to zero", d, 32'd0);
        rd(8'h08, d); check("R7 pending on match", d & 32'h10, 32'h10);
        rd(8'h50, d); check("R7 stays enabled", d, 32'h11);
        ticks(1'b1, 1'b0, 4);
        rd(8'h58, d); check("R7 second period", d, 32'd1);
        wr(8'h50, 32'h10);
        wr(8'h08, 32'h10);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(8'h6C, 32'd1);
        wr(8'h60, 32'h13);
        fast_tick = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h08, 32'h20);
        fast_tick = 1'b0;
        rd(8'h08, d); check("R12 match beats ack", d & 32'h20, 32'h20);
        wr(8'h60, 32'h10);
        wr(8'h08, 32'h20);
        rd(8'h08, d); check("R10 ack after stop", d & 32'h20, 32'h0);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(8'h10, 32'h33);
        ticks(1'b1, 1'b0, 256);
        bus_addr = 8'h18; #1;
        check("R8 narrow counter wrapped", small_rdata, 32'd0);
        check("R4 wide counter kept counting", bus_rdata, 32'd256);
        bus_addr = 8'h08; #1;
        check("R8 no pending in free-run", small_rdata & 32'h1, 32'h0);
        check("R8 no pending past compare", bus_rdata & 32'h1, 32'h0);
        ticks(1'b1, 1'b0, 3);
        bus_addr = 8'h18; #1;
        check("R8 counts on after wrap", small_rdata, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_count();
        t_ctrl_swallow();
        t_prescale();
        t_oneshot();
        t_mode_alt();
        t_repeat();
        t_collide();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule